// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives and holds the status and control flags of a 16-bit processor. Each cycle the datapath presents two operands, the result it produced, an operand size and an operation class. When the update strobe is high the block works out carry, parity, auxiliary carry, zero, sign and overflow from those values and writes them into a 16-bit flag register. Three control flags (trace, interrupt enable, direction) do not respond to arithmetic. Each has its own set and clear strobe.

A whole-register load writes a complete 16-bit word into the register, as a flag restore from the stack does. The load takes priority over every other write in the same cycle. Bits that carry no flag always read back a fixed pattern. All writes become visible on `flags_q` after the next rising clock edge.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset `flags_q` reads 16'hF002. The flag positions are carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trace 8, interrupt enable 9, direction 10 and overflow 11. Bits 1 and 12..15 always read 1, and bits 3 and 5 always read 0.
- R2: On a status update, parity (bit 2) is 1 when the count of one bits in `result[7:0]` is even. This holds in both sizes.
- R3: On an add or subtract update, auxiliary carry (bit 4) is 1 on a carry out of, or a borrow into, bit 3.
- R4: `size_word`=1 selects 16-bit width and 0 selects 8-bit width, where only the low byte counts. Sign (bit 7) is the top bit of the result at that width. Zero (bit 6) is 1 when the result at that width is all zeros.
- R5: Carry (bit 0) is the carry out of the top bit for add (`op_class`=0) and the borrow into it for subtract (`op_class`=1). For shift (`op_class`=3) carry is taken from `shift_co`.
- R6: Overflow (bit 11) is 1 when the signed add or subtract result does not fit the selected width. For shift, overflow is 1 when the top bit of `result` differs from the top bit of `opnd_a`.
- R7: A logic update (`op_class`=2) clears carry and overflow. Logic and shift updates leave auxiliary carry unchanged.
- R8: Each control flag is set by its set strobe and cleared by its clear strobe. When both strobes are high the set wins. Status updates never change bits 8..10.
- R9: `load_en` writes `load_word` into the register with the fixed bits forced. In that cycle it overrides any status update and any control strobe.
- R10: The register holds its value in cycles with no update, no strobe and no load. Every write appears on `flags_q` one clock edge after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Status update strobe |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 shift |
| size_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opnd_a | input | 16 | First operand (minuend for subtract) |
| opnd_b | input | 16 | Second operand (subtrahend for subtract) |
| result | input | 16 | Datapath result |
| shift_co | input | 1 | Carry-out from the shifter |
| set_trace | input | 1 | Set trace flag |
| clr_trace | input | 1 | Clear trace flag |
| set_inten | input | 1 | Set interrupt-enable flag |
| clr_inten | input | 1 | Clear interrupt-enable flag |
| set_dir | input | 1 | Set direction flag |
| clr_dir | input | 1 | Clear direction flag |
| load_en | input | 1 | Whole-register load strobe |
| load_word | input | 16 | Word to load |
| flags_q | output | 16 | Flag register |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it: status flags, control strobes and whole-register loads alike, with no combinational path to `flags_q`. The bench drives a stimulus at a falling edge and advances its behavioural model at the following rising edge. It compares `flags_q` with the model at the next falling edge, so every clock is checked half a period after the register updates. Directed cases cover signed overflow, byte-mode carry and zero, borrows, odd parity with a nonzero high byte, strobe conflicts and load priority. A random run follows them.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W  = 16;
  localparam int CF_B    = 0;
  localparam int PF_B    = 2;
  localparam int AF_B    = 4;
  localparam int ZF_B    = 6;
  localparam int SF_B    = 7;
  localparam int TF_B    = 8;
  localparam int IF_B    = 9;
  localparam int DF_B    = 10;
  localparam int OF_B    = 11;
  localparam int N_CTRL  = 3;
  localparam int CTRL_LO = TF_B;

  localparam logic [FLAG_W-1:0] FIX_MASK = 16'hF02A;
  localparam logic [FLAG_W-1:0] FIX_VAL  = 16'hF002;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_SUB   = 2'd1,
    OP_LOGIC = 2'd2,
    OP_SHIFT = 2'd3
  } op_class_e;

  // even number of ones -> 1
  function automatic logic even_parity(input logic [7:0] v);
    return ~(^v);
  endfunction

  // carry out of (add) or borrow into (sub) a bit position, from its bits
  function automatic logic msb_carry(input logic a, input logic b,
                                     input logic r, input logic sub);
    if (sub) return (~a & b) | ((~a | b) & r);
    else     return (a & b) | ((a | b) & ~r);
  endfunction

  // signed overflow from top bits of operands and result
  function automatic logic signed_ovf(input logic a, input logic b,
                                      input logic r, input logic sub);
    if (sub) return (a ^ b) & (a ^ r);
    else     return ~(a ^ b) & (a ^ r);
  endfunction

  function automatic logic [FLAG_W-1:0] force_fixed(input logic [FLAG_W-1:0] d);
    return (d & ~FIX_MASK) | FIX_VAL;
  endfunction
endpackage

// File: rtl/flag_status_calc.sv
module flag_status_calc
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        op_class,
  input  logic              size_word,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              shift_co,
  input  logic              cur_af,
  output logic              cf_n,
  output logic              pf_n,
  output logic              af_n,
  output logic              zf_n,
  output logic              sf_n,
  output logic              of_n
);
  localparam int HALF_W = DATA_W / 2;

  op_class_e op;
  logic a_top, b_top, r_top, is_sub, arith, nib_cy;

  assign op     = op_class_e'(op_class);
  assign a_top  = size_word ? opnd_a[DATA_W-1] : opnd_a[HALF_W-1];
  assign b_top  = size_word ? opnd_b[DATA_W-1] : opnd_b[HALF_W-1];
  assign r_top  = size_word ? result[DATA_W-1] : result[HALF_W-1];
  assign is_sub = (op == OP_SUB);
  assign arith  = (op == OP_ADD) || (op == OP_SUB);
  assign nib_cy = opnd_a[4] ^ opnd_b[4] ^ result[4];

  always_comb begin
    pf_n = even_parity(result[7:0]);
    sf_n = r_top;
    zf_n = size_word ? (result == '0) : (result[HALF_W-1:0] == '0);
    af_n = arith ? nib_cy : cur_af;
    unique case (op)
      OP_ADD, OP_SUB: begin
        cf_n = msb_carry(a_top, b_top, r_top, is_sub);
        of_n = signed_ovf(a_top, b_top, r_top, is_sub);
      end
      OP_LOGIC: begin
        cf_n = 1'b0;
        of_n = 1'b0;
      end
      default: begin
        cf_n = shift_co;
        of_n = a_top ^ r_top;
      end
    endcase
  end
endmodule

// File: rtl/flag_ctrl_bits.sv
module flag_ctrl_bits #(
  parameter int N = 3
) (
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  input  logic [N-1:0] cur,
  output logic [N-1:0] nxt,
  output logic         any_strobe
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // set has priority over clear
    assign nxt[i] = set_v[i] ? 1'b1 : (clr_v[i] ? 1'b0 : cur[i]);
  end
  assign any_strobe = |{set_v, clr_v};
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [FLAG_W-1:0] d,
  output logic [FLAG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= FIX_VAL;
    else if (we) q <= force_fixed(d);
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic              size_word,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              shift_co,
  input  logic              set_trace,
  input  logic              clr_trace,
  input  logic              set_inten,
  input  logic              clr_inten,
  input  logic              set_dir,
  input  logic              clr_dir,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_word,
  output logic [FLAG_W-1:0] flags_q
);
  logic cf_n, pf_n, af_n, zf_n, sf_n, of_n;
  logic [N_CTRL-1:0] ctrl_nxt;
  logic              ctrl_strobe;
  logic              status_wr;
  logic              load_wr;
  logic              reg_we;
  logic [FLAG_W-1:0] merged;
  logic [FLAG_W-1:0] reg_d;

  flag_status_calc #(.DATA_W(DATA_W)) u_calc (
    .op_class (op_class),
    .size_word(size_word),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .shift_co (shift_co),
    .cur_af   (flags_q[AF_B]),
    .cf_n     (cf_n),
    .pf_n     (pf_n),
    .af_n     (af_n),
    .zf_n     (zf_n),
    .sf_n     (sf_n),
    .of_n     (of_n)
  );

  flag_ctrl_bits #(.N(N_CTRL)) u_ctrl (
    .set_v     ({set_dir, set_inten, set_trace}),
    .clr_v     ({clr_dir, clr_inten, clr_trace}),
    .cur       (flags_q[CTRL_LO +: N_CTRL]),
    .nxt       (ctrl_nxt),
    .any_strobe(ctrl_strobe)
  );

  assign load_wr   = load_en;
  assign status_wr = upd_en & ~load_en;
  assign reg_we    = load_en | upd_en | ctrl_strobe;

  always_comb begin
    merged = flags_q;
    if (status_wr) begin
      merged[CF_B] = cf_n;
      merged[PF_B] = pf_n;
      merged[AF_B] = af_n;
      merged[ZF_B] = zf_n;
      merged[SF_B] = sf_n;
      merged[OF_B] = of_n;
    end
    merged[CTRL_LO +: N_CTRL] = ctrl_nxt;
    reg_d = load_wr ? load_word : merged;
  end

  flag_reg u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .d    (reg_d),
    .q    (flags_q)
  );
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              upd_en,
  input logic              load_en,
  input logic [1:0]        op_class,
  input logic [7:0]        res_lo,
  input logic [FLAG_W-1:0] load_word,
  input logic [FLAG_W-1:0] flags_q,
  input logic              status_wr,
  input logic              load_wr,
  input logic              ctrl_strobe
);
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & FIX_MASK) == FIX_VAL);

  a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> flags_q[PF_B] == ~(^$past(res_lo)));

  a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && op_class == 2'd2) |=>
      (!flags_q[CF_B] && !flags_q[OF_B] && flags_q[AF_B] == $past(flags_q[AF_B])));

  a_r8_ctrl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && !ctrl_strobe) |=> $stable(flags_q[DF_B:TF_B]));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> flags_q == (($past(load_word) & ~FIX_MASK) | FIX_VAL));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !load_en && !ctrl_strobe) |=> $stable(flags_q));
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_en     (upd_en),
  .load_en    (load_en),
  .op_class   (op_class),
  .res_lo     (result[7:0]),
  .load_word  (load_word),
  .flags_q    (flags_q),
  .status_wr  (status_wr),
  .load_wr    (load_wr),
  .ctrl_strobe(ctrl_strobe)
);

// File: tb/tb_alu_flag_unit.sv
`timescale 1ns/1ps
module tb_alu_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 0, size_word = 0, shift_co = 0, load_en = 0;
  logic [1:0]  op_class = 0;
  logic [15:0] opnd_a = 0, opnd_b = 0, result = 0, load_word = 0;
  logic        set_trace = 0, clr_trace = 0, set_inten = 0, clr_inten = 0, set_dir = 0, clr_dir = 0;
  logic [15:0] flags_q;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q;

  always #10 clk = ~clk;

  alu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .shift_co(shift_co), .set_trace(set_trace), .clr_trace(clr_trace),
    .set_inten(set_inten), .clr_inten(clr_inten), .set_dir(set_dir),
    .clr_dir(clr_dir), .load_en(load_en), .load_word(load_word), .flags_q(flags_q)
  );

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  function automatic logic [15:0] model(
    input logic [15:0] cur, input int op, input bit wd, input int a, input int b,
    input int r, input bit co, input bit upd, input bit [5:0] st, input bit ld,
    input logic [15:0] lw);
    logic [15:0] n;
    int w, m, am, bm, rm, ones, s;
    n = cur;
    if (ld) return (lw & 16'h0FD5) | 16'hF002;
    if (upd) begin
      w = wd ? 16 : 8;
      m = (1 << w) - 1;
      am = a & m; bm = b & m; rm = r & m;
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      n[2] = (ones % 2) == 0;
      n[6] = (rm == 0);
      n[7] = ((rm >> (w - 1)) & 1) == 1;
      case (op)
        0: begin
          n[0] = (am + bm) > m;
          n[4] = ((a & 15) + (b & 15)) > 15;
          s = sx(am, w) + sx(bm, w);
          n[11] = (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
        end
        1: begin
          n[0] = am < bm;
          n[4] = (a & 15) < (b & 15);
          s = sx(am, w) - sx(bm, w);
          n[11] = (s > (1 << (w - 1)) - 1) || (s < -(1 << (w - 1)));
        end
        2: begin
          n[0] = 1'b0;
          n[11] = 1'b0;
        end
        default: begin
          n[0] = co;
          n[11] = ((am >> (w - 1)) & 1) != ((rm >> (w - 1)) & 1);
        end
      endcase
    end
    for (int i = 0; i < 3; i++) begin
      if (st[2*i])        n[8+i] = 1'b1;
      else if (st[2*i+1]) n[8+i] = 1'b0;
    end
    return n;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (flags_q !== exp_q) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, flags_q, exp_q);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the update
  task automatic step(input int op, input bit wd, input int a, input int b, input int r,
                      input bit co, input bit upd, input bit [5:0] st, input bit ld,
                      input logic [15:0] lw, input string tag);
    op_class = op[1:0]; size_word = wd; opnd_a = a[15:0]; opnd_b = b[15:0];
    result = r[15:0]; shift_co = co; upd_en = upd; load_en = ld; load_word = lw;
    {clr_dir, set_dir, clr_inten, set_inten, clr_trace, set_trace} = st;
    @(posedge clk);
    exp_q = model(exp_q, op, wd, a, b, r, co, upd, st, ld, lw);
    @(negedge clk);
    upd_en = 0; load_en = 0;
    {clr_dir, set_dir, clr_inten, set_inten, clr_trace, set_trace} = 6'b0;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int a, b, r, op;
    bit wd;
    exp_q = 16'hF002;
    repeat (3) @(negedge clk);
    check("R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step(0, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, 1, 6'b0, 0, 0, "R6 word signed overflow");
    step(0, 1, 16'hFFFF, 16'h0001, 16'h0000, 0, 1, 6'b0, 0, 0, "R5 word carry and zero");
    step(0, 0, 16'h0080, 16'h0080, 16'h0100, 0, 1, 6'b0, 0, 0, "R4 byte carry overflow zero");
    step(1, 1, 16'h0000, 16'h0001, 16'hFFFF, 0, 1, 6'b0, 0, 0, "R3 borrow from nibble");
    step(1, 0, 16'h0080, 16'h0001, 16'h007F, 0, 1, 6'b0, 0, 0, "R6 byte subtract overflow");
    step(2, 1, 16'h0701, 16'h0701, 16'h0701, 0, 1, 6'b0, 0, 0, "R2 odd low byte parity");
    step(1, 1, 16'h0010, 16'h0001, 16'h000F, 0, 1, 6'b0, 0, 0, "R3 set aux carry");
    step(2, 1, 16'h00FF, 16'h0000, 16'h00FF, 0, 1, 6'b0, 0, 0, "R7 logic keeps aux carry");
    step(3, 1, 16'h4000, 16'h0000, 16'h8000, 1, 1, 6'b0, 0, 0, "R5 shift carry from input");
    step(3, 0, 16'h0040, 16'h0000, 16'h0020, 0, 1, 6'b0, 0, 0, "R6 shift byte no overflow");
    step(0, 1, 0, 0, 0, 0, 0, 6'b010101, 0, 0, "R8 set all control");
    step(0, 1, 16'h1234, 16'h1111, 16'h2345, 0, 1, 6'b0, 0, 0, "R8 arithmetic keeps control");
    step(0, 1, 0, 0, 0, 0, 0, 6'b101010, 0, 0, "R8 clear all control");
    step(0, 1, 0, 0, 0, 0, 0, 6'b001111, 0, 0, "R8 set beats clear");
    step(0, 1, 0, 0, 0, 0, 0, 6'b0, 0, 0, "R10 idle hold");
    step(0, 1, 16'hFFFF, 16'h0001, 16'h0000, 0, 1, 6'b111111, 1, 16'hFFFF, "R9 load all ones wins");
    step(0, 1, 0, 0, 0, 0, 0, 6'b0, 1, 16'h0000, "R9 load zeros fixed bits");
    step(0, 1, 0, 0, 0, 0, 0, 6'b0, 0, 0, "R10 idle after load");

    for (int k = 0; k < 400; k++) begin
      op = int'($urandom_range(0, 3));
      wd = 1'($urandom_range(0, 1));
      a = int'($urandom_range(0, 65535));
      b = int'($urandom_range(0, 65535));
      case (op)
        0: r = (a + b) & 16'hFFFF;
        1: r = (a - b) & 16'hFFFF;
        2: r = a ^ b;
        default: r = int'($urandom_range(0, 65535));
      endcase
      step(op, wd, a, b, r, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
           6'($urandom_range(0, 63) & ($urandom_range(0, 1) ? 63 : 0)),
           ($urandom_range(0, 15) == 0), 16'($urandom_range(0, 65535)), "R4 random mix");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule